// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between an 8-bit CPU with a 16-bit logical address and a 1 MB physical memory. It cuts the logical space into sixteen 4 KB pages and, through a table of sixteen 8-bit page registers, places each of them on any of the 256 physical 4 KB frames. The top four logical address bits pick a register. That register supplies the upper eight physical address bits. The low twelve bits pass through unchanged.

Each register holds its upper physical nibble as written. Its lower nibble is stored inverted. After reset every register holds an identity map into the lowest 64 KB. The topmost 256 bytes of logical space are never translated. In that window a read returns boot ROM data and a write loads the page register chosen by the four low address bits. Firmware at the top of memory can therefore set up the table while it runs from the same addresses. The block also flags accesses in the top 8 KB of logical space, so that the downstream I/O and ROM decoder can ignore the upper physical nibble there.

Top module: `pageMapUnit`

## Requirements
- R1: Outside the window (logical addresses 0000 to FEFF), physAddr[11:0] equals cpuAddr[11:0]. physAddr[19:16] equals bits 7..4 of page register cpuAddr[15:12]. physAddr[15:12] equals the inverse of bits 3..0 of that register.
- R2: In the window (cpuAddr[15:8] equal to FF), physAddr equals {4'h0, cpuAddr}. No page register takes part.
- R3: A valid read in the window asserts romRead. cpuRdData then equals romRdData, and memRead stays low.
- R4: A valid write in the window loads cpuWrData into page register cpuAddr[3:0] at the next rising clock edge, whatever cpuAddr[7:4] is. memWrite stays low. The new value is used from that edge onward.
- R5: A valid write outside the window asserts memWrite and changes no page register.
- R6: While rstN is low, and after it is released with no window writes, page register N holds {4'h0, ~N}, so physAddr equals {4'h0, cpuAddr}.
- R7: highSpace is high exactly when cpuAddr[15:13] is 3'b111 (logical E000 to FFFF), whether or not the cycle is valid.
- R8: With cpuValid low, memRead, memWrite and romRead stay low and no page register changes.
- R9: A valid read outside the window asserts memRead, and cpuRdData equals memRdData.
- R10: At most one of memRead, memWrite and romRead is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; page registers load on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Logical address from the CPU |
| cpuValid | input | 1 | The current cycle is a real memory access |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuWrData | input | 8 | Write data from the CPU |
| romRdData | input | 8 | Data from the boot ROM |
| memRdData | input | 8 | Data from the translated memory system |
| cpuRdData | output | 8 | Read data returned to the CPU |
| physAddr | output | 20 | Physical address |
| memRead | output | 1 | Read strobe for translated memory |
| memWrite | output | 1 | Write strobe for translated memory |
| romRead | output | 1 | Read strobe for the boot ROM in the window |
| highSpace | output | 1 | Logical address lies in E000 to FFFF |

## Verification
The bench aims at the window edges FEFF and FF00. A design that misplaced the window compare would either translate a boot ROM fetch through page F or send a page-F memory write into the register table. It writes window addresses whose bits 7..4 are not all ones, such as FF35. A design that decoded only FFF0 to FFFF would then leave the register unchanged, and the next access to that page would show the old frame. It checks the reset identity map on all sixteen pages and writes patterns with unequal nibbles. These catch an inversion applied to the wrong nibble, or to none. It also checks that a write with cpuValid low leaves the table as it was, and that highSpace switches between DFFF and E000.

// File: rtl/pmuPkg.sv
package pmuPkg;
  // Strobes from the access decoder to the translation datapath
  typedef struct packed {
    logic bypass;   // address lies in the untranslated top window
    logic regWr;    // load page register selected by low address bits
    logic romRd;    // window read: steer ROM data back
    logic memRd;    // translated read
    logic memWr;    // translated write
  } pmuStrobes_t;
endpackage

// File: rtl/pmuControl.sv
module pmuControl
  import pmuPkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int WIN_W  = 8,   // upper address bits that must all be ones for the window
  parameter int HIGH_W = 3    // upper address bits that must all be ones for highSpace
) (
  input  logic [LOG_W-1:0] cpuAddr,
  input  logic             cpuValid,
  input  logic             cpuWrite,
  output pmuStrobes_t      strobes,
  output logic             highSpace
);
  logic inWindow;

  assign inWindow  = &cpuAddr[LOG_W-1 -: WIN_W];
  assign highSpace = &cpuAddr[LOG_W-1 -: HIGH_W];

  always_comb begin
    strobes.bypass = inWindow;
    strobes.regWr  = cpuValid &  cpuWrite &  inWindow;
    strobes.romRd  = cpuValid & ~cpuWrite &  inWindow;
    strobes.memRd  = cpuValid & ~cpuWrite & ~inWindow;
    strobes.memWr  = cpuValid &  cpuWrite & ~inWindow;
  end
endmodule

// File: rtl/pmuDatapath.sv
module pmuDatapath
  import pmuPkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int IDX_W   = 4,
  parameter int FRAME_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LOG_W-1:0]           cpuAddr,
  input  logic [DATA_W-1:0]          cpuWrData,
  input  logic [DATA_W-1:0]          romRdData,
  input  logic [DATA_W-1:0]          memRdData,
  input  pmuStrobes_t                strobes,
  output logic [FRAME_W+LOG_W-IDX_W-1:0] physAddr,
  output logic [DATA_W-1:0]          cpuRdData
);
  localparam int OFF_W   = LOG_W - IDX_W;
  localparam int PHYS_W  = FRAME_W + OFF_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int INV_W   = IDX_W;            // stored-inverted low bits of an entry
  localparam int DIR_W   = FRAME_W - INV_W;  // stored-direct high bits of an entry

  logic [FRAME_W-1:0] pageReg [ENTRIES];
  logic [IDX_W-1:0]   wrIdx;
  logic [IDX_W-1:0]   rdIdx;
  logic [FRAME_W-1:0] selEntry;

  assign wrIdx = cpuAddr[IDX_W-1:0];
  assign rdIdx = cpuAddr[LOG_W-1 -: IDX_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    localparam logic [IDX_W-1:0]   IDX_V = IDX_W'(i);
    localparam logic [FRAME_W-1:0] RST_V = {{DIR_W{1'b0}}, ~IDX_V};
    always_ff @(posedge clk) begin
      if (!rstN)
        pageReg[i] <= RST_V;
      else if (strobes.regWr && wrIdx == IDX_V)
        pageReg[i] <= cpuWrData[FRAME_W-1:0];
    end
  end

  assign selEntry = pageReg[rdIdx];

  always_comb begin
    if (strobes.bypass)
      physAddr = PHYS_W'(cpuAddr);
    else
      physAddr = {selEntry[FRAME_W-1:INV_W], ~selEntry[INV_W-1:0], cpuAddr[OFF_W-1:0]};
  end

  assign cpuRdData = strobes.romRd ? romRdData : memRdData;
endmodule

// File: rtl/pageMapUnit.sv
module pageMapUnit
  import pmuPkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int IDX_W   = 4,
  parameter int FRAME_W = 8,
  parameter int DATA_W  = 8,
  parameter int WIN_W   = 8,
  parameter int HIGH_W  = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [LOG_W-1:0]               cpuAddr,
  input  logic                           cpuValid,
  input  logic                           cpuWrite,
  input  logic [DATA_W-1:0]              cpuWrData,
  input  logic [DATA_W-1:0]              romRdData,
  input  logic [DATA_W-1:0]              memRdData,
  output logic [DATA_W-1:0]              cpuRdData,
  output logic [FRAME_W+LOG_W-IDX_W-1:0] physAddr,
  output logic                           memRead,
  output logic                           memWrite,
  output logic                           romRead,
  output logic                           highSpace
);
  pmuStrobes_t strobes;

  pmuControl #(.LOG_W(LOG_W), .WIN_W(WIN_W), .HIGH_W(HIGH_W)) uCtrl (
    .cpuAddr  (cpuAddr),
    .cpuValid (cpuValid),
    .cpuWrite (cpuWrite),
    .strobes  (strobes),
    .highSpace(highSpace)
  );

  pmuDatapath #(.LOG_W(LOG_W), .IDX_W(IDX_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddr  (cpuAddr),
    .cpuWrData(cpuWrData),
    .romRdData(romRdData),
    .memRdData(memRdData),
    .strobes  (strobes),
    .physAddr (physAddr),
    .cpuRdData(cpuRdData)
  );

  assign memRead  = strobes.memRd;
  assign memWrite = strobes.memWr;
  assign romRead  = strobes.romRd;
endmodule

// File: rtl/pageMapUnit_chk.sv
module pageMapUnit_chk #(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [LOG_W-1:0]  cpuAddr,
  input logic              cpuValid,
  input logic              cpuWrite,
  input logic [DATA_W-1:0] romRdData,
  input logic [DATA_W-1:0] memRdData,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [PHYS_W-1:0] physAddr,
  input logic              memRead,
  input logic              memWrite,
  input logic              romRead
);
  logic inWin;
  logic pastOk;
  assign inWin = &cpuAddr[LOG_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R1: offset bits always pass straight through
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[11:0] == cpuAddr[11:0]);

  // R2: window addresses bypass the table
  assert_window_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    inWin |-> physAddr == PHYS_W'(cpuAddr));

  // R3: ROM data steered back on window reads
  assert_rom_steer_R3: assert property (@(posedge clk) disable iff (!rstN)
    romRead |-> (cpuRdData == romRdData && inWin && !cpuWrite));

  // R5: memory writes never aimed at the window
  assert_memwr_outside_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> !inWin);

  // R8: idle cycles raise no strobe
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cpuValid |-> !(memRead || memWrite || romRead));

  // R9: memory data steered back on translated reads
  assert_mem_steer_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> cpuRdData == memRdData);

  // R10: strobes mutually exclusive
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRead, memWrite, romRead}));

  // R4: translation only changes after a window write or an address change
  assert_map_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $stable(cpuAddr) && !$past(cpuValid && cpuWrite && inWin)) |-> $stable(physAddr));
endmodule

bind pageMapUnit pageMapUnit_chk #(.LOG_W(16), .PHYS_W(20), .DATA_W(8)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .cpuValid (cpuValid),
  .cpuWrite (cpuWrite),
  .romRdData(romRdData),
  .memRdData(memRdData),
  .cpuRdData(cpuRdData),
  .physAddr (physAddr),
  .memRead  (memRead),
  .memWrite (memWrite),
  .romRead  (romRead)
);

// File: tb/pageMapUnit_test.sv
module pageMapUnit_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cpuAddr;
  logic        cpuValid, cpuWrite;
  logic [7:0]  cpuWrData, romRdData, memRdData, cpuRdData;
  logic [19:0] physAddr;
  logic        memRead, memWrite, romRead, highSpace;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  pageMapUnit uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuWrData(cpuWrData), .romRdData(romRdData), .memRdData(memRdData), .cpuRdData(cpuRdData),
    .physAddr(physAddr), .memRead(memRead), .memWrite(memWrite), .romRead(romRead),
    .highSpace(highSpace)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at addr %h", req, act, exp, cpuAddr);
    end
  endtask

  function automatic logic [19:0] expPhys(logic [15:0] a);
    logic [7:0] e;
    e = model[a[15:12]];
    if (a[15:8] == 8'hFF) return {4'h0, a};
    return {e[7:4], ~e[3:0], a[11:0]};
  endfunction

  task automatic access(logic [15:0] a, logic v, logic w, logic [7:0] d);
    logic win;
    @(negedge clk);
    cpuAddr = a; cpuValid = v; cpuWrite = w; cpuWrData = d;
    romRdData = 8'($urandom); memRdData = 8'($urandom);
    #1;
    win = (a[15:8] == 8'hFF);
    if (win) check("R2 window bypass", physAddr, expPhys(a));
    else     check("R1 translation", physAddr, expPhys(a));
    check("R7 highSpace", highSpace, a[15:13] == 3'b111);
    check("R3/R8 romRead", romRead, v & ~w & win);
    check("R9/R8 memRead", memRead, v & ~w & ~win);
    check("R5/R8 memWrite", memWrite, v & w & ~win);
    check("R10 one strobe", 32'(memRead) + 32'(memWrite) + 32'(romRead) <= 1, 1);
    if (v && !w && win)  check("R3 rom data", cpuRdData, romRdData);
    if (v && !w && !win) check("R9 mem data", cpuRdData, memRdData);
    @(posedge clk);
    if (v && w && win) model[a[3:0]] = d;   // R4
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    rstN = 1'b0; cpuAddr = '0; cpuValid = 0; cpuWrite = 0;
    cpuWrData = '0; romRdData = '0; memRdData = '0;
    for (int i = 0; i < 16; i++) model[i] = {4'h0, ~4'(i)};
    repeat (3) @(posedge clk);
    // R6: identity map visible during reset
    @(negedge clk); cpuAddr = 16'h7ABC; #1;
    check("R6 reset identity", physAddr, 20'h07ABC);
    @(negedge clk); rstN = 1'b1;
    // R6: all pages identity after release
    for (int i = 0; i < 16; i++) begin
      access({4'(i), 12'h5A3}, 1, 0, 8'h00);
      check("R6 identity page", physAddr, {4'h0, 4'(i), 12'h5A3});
    end
    // R1/R2 window edges
    access(16'hFEFF, 1, 0, 0);
    access(16'hFF00, 1, 0, 0);
    access(16'hDFFF, 1, 0, 0);
    access(16'hE000, 1, 0, 0);
    // R4 write via FFF3 and FF35 (bits 7..4 not all ones)
    access(16'hFFF3, 1, 1, 8'h9C);
    access(16'h3123, 1, 0, 0);
    check("R4 FFF3 write", physAddr, 20'h93123);
    access(16'hFF35, 1, 1, 8'h2E);
    access(16'h5FFF, 1, 0, 0);
    check("R4 FF35 write", physAddr, 20'h21FFF);
    // R8 invalid window write leaves page 2 identity
    access(16'hFFF2, 0, 1, 8'hAA);
    access(16'h2000, 1, 0, 0);
    check("R8 invalid write ignored", physAddr, 20'h02000);
    // R5 memory write does not touch page 3 register
    access(16'hFEF3, 1, 1, 8'h55);
    access(16'h3000, 1, 0, 0);
    check("R5 outside write ignored", physAddr, 20'h93000);
    // page F remap and window still bypassed
    access(16'hFFFF, 1, 1, 8'hF0);
    access(16'hF123, 1, 1, 8'h11);
    check("R1 page F remap", physAddr, 20'hFF123);
    access(16'hFF80, 1, 0, 0);
    check("R2 window after remap", physAddr, 20'h0FF80);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(0, 3) == 0) a[15:8] = 8'hFF;
      access(a, 1'($urandom_range(0, 5) != 0), 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule